// File: doc/BRIEF.md
# Bridge Request Decoder with Endian Selection

This block is one pipeline stage on the request path between a processor-side port and two downstream bus ports: one for PCI and one for HyperTransport. Each request carries a 40-bit physical address and a 64-bit write-data word. The block sorts the request into one of four classes:

- the 512 MB memory-mapped device window;
- a programmable HyperTransport sub-range inside that window;
- the HyperTransport expansion space;
- configuration space.

Every decoded request gets one of two endian policies: match-byte-lane or match-bit-lane. The policy is picked per access by an address alias bit. That bit is removed or rewritten before the request goes downstream. In big-endian mode the data is byte-reversed for match-byte-lane requests.

The decoded request leaves through a single output register with a valid/ready handshake. A small register port holds three settings: the HyperTransport sub-range base and limit, in 1 MB granules, and the expansion-endian enable. A request that matches no region is flagged as an error and carries no target.

The `HAS_HT` parameter selects a variant without HyperTransport. In that variant every window access goes to PCI and expansion space is reported as an error.

Top module: `bridge_req_decode`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The sub-range base register resets to all ones and the limit register resets to 0, so no window address routes to HyperTransport. The expansion-endian enable resets to 0.
- R2: An address in 0x00_4000_0000..0x00_5FFF_FFFF goes to PCI with match-byte-lane policy and an unchanged address. Encodings: `out_target` 1 = PCI, 2 = HT, 0 = none. `out_space` 0 = window, 1 = expansion, 2 = configuration, 3 = miss. `out_policy` 0 = match-byte-lane, 1 = match-bit-lane.
- R3: An address in the window alias 0x00_6000_0000..0x00_7FFF_FFFF uses match-bit-lane policy and leaves with bit 29 cleared.
- R4: A window access whose granule index (forwarded address minus 0x00_4000_0000, shifted right by 20) lies within [base, limit], inclusive, goes to HT. All other window accesses go to PCI.
- R5: With the expansion enable at 0, any address in 0x80_0000_0000..0xF7_FFFF_FFFF goes to HT with match-byte-lane policy and an unchanged address.
- R6: With the expansion enable at 1, addresses 0xC0_0000_0000..0xDF_FFFF_FFFF use match-bit-lane policy and leave with bit 38 cleared. The rest of expansion space stays match-byte-lane and unchanged.
- R7: Configuration space is 0x00_1E00_0000..0x00_1FFF_FFFF, with its alias at 0x00_3E00_0000..0x00_3FFF_FFFF. It goes to PCI with `out_space` 2. Bit 29 selects the policy and is cleared in the forwarded address.
- R8: An address outside every region leaves with `out_err` 1, `out_target` 0 and `out_space` 3.
- R9: With `big_endian` 1 and match-byte-lane policy, the 8 data bytes are reversed (byte 0 swaps with byte 7). With match-bit-lane policy, or with `big_endian` 0, the data passes unchanged.
- R10: `in_ready` equals `!out_valid || out_ready`. A request accepted on one edge is valid after that edge. The output fields hold stable while `out_valid` is 1 and `out_ready` is 0.
- R11: Register writes use `reg_sel` 0 = sub-range base, 1 = sub-range limit, 2 = expansion enable (`reg_wdata` bit 0). A write affects requests accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Setting write strobe |
| reg_sel | input | 2 | Setting select |
| reg_wdata | input | 9 | Setting write value |
| big_endian | input | 1 | Processor runs big-endian |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_addr | input | 40 | Physical address |
| in_data | input | 64 | Write data |
| out_valid | output | 1 | Decoded request present |
| out_ready | input | 1 | Downstream takes the decoded request |
| out_target | output | 2 | Destination port |
| out_space | output | 2 | Region class |
| out_policy | output | 1 | Endian policy |
| out_err | output | 1 | Request hit no region |
| out_addr | output | 40 | Forwarded address |
| out_data | output | 64 | Lane-adjusted data |

## Verification
Each decoded result appears one edge after the request is accepted. The bench therefore checks `out_valid` at the falling edge that follows acceptance. It compares the decoded fields when the monitor raises `out_ready` for that item.

Register writes complete on the write edge. The bench sends the next request at least one cycle later, so expected values always use the updated settings.

While `out_ready` is low, the bench takes a snapshot of the outputs. At the next falling edge it confirms that every field is unchanged.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_PCI = 2'd1, TGT_HT = 2'd2} br_tgt_e;
   typedef enum logic [1:0] {SP_WIN = 2'd0, SP_EXP = 2'd1, SP_CFG = 2'd2, SP_MISS = 2'd3} br_space_e;
   typedef enum logic {POL_BYTE = 1'b0, POL_BIT = 1'b1} br_pol_e;

   typedef struct packed {
      br_tgt_e   tgt;
      br_space_e space;
      br_pol_e   pol;
      logic      err;
   } br_cls_t;
endpackage

// File: rtl/br_ht_regs.sv
module br_ht_regs #(
   parameter int GRAN_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [GRAN_W-1:0] reg_wdata,
   output logic [GRAN_W-1:0] ht_base,
   output logic [GRAN_W-1:0] ht_limit,
   output logic              exp_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ht_base  <= '1;
         ht_limit <= '0;
         exp_en   <= 1'b0;
      end else if (reg_we) begin
         case (reg_sel)
            2'd0:    ht_base  <= reg_wdata;
            2'd1:    ht_limit <= reg_wdata;
            2'd2:    exp_en   <= reg_wdata[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/br_lane_swap.sv
module br_lane_swap #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] din,
   input  logic              swap,
   output logic [DATA_W-1:0] dout
);
   localparam int NBYTES = DATA_W / 8;
   logic [DATA_W-1:0] rev;

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign rev[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
      end
   endgenerate

   assign dout = swap ? rev : din;
endmodule

// File: rtl/br_addr_class.sv
module br_addr_class #(
   parameter int                ADDR_W        = 40,
   parameter int                WIN_BITS      = 29,
   parameter logic [ADDR_W-1:0] WIN_BASE      = 40'h00_4000_0000,
   parameter logic [ADDR_W-1:0] CFG_BASE      = 40'h00_1E00_0000,
   parameter int                CFG_BITS      = 25,
   parameter int                HT_GRAN_BITS  = 20,
   parameter logic [ADDR_W-1:0] EXP_LO        = 40'h80_0000_0000,
   parameter logic [ADDR_W-1:0] EXP_HI        = 40'hF7_FFFF_FFFF,
   parameter logic [ADDR_W-1:0] EXP_ALIAS_END = 40'hE0_0000_0000,
   parameter int                EXP_ALIAS_BIT = 38,
   parameter bit                HAS_HT        = 1'b1
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [WIN_BITS-HT_GRAN_BITS-1:0] ht_base,
   input  logic [WIN_BITS-HT_GRAN_BITS-1:0] ht_limit,
   input  logic                           exp_en,
   output br_pkg::br_cls_t                cls,
   output logic [ADDR_W-1:0]              fwd_addr
);
   import br_pkg::*;

   localparam int ALIAS = WIN_BITS;
   localparam int GRAN_W = WIN_BITS - HT_GRAN_BITS;

   logic              win_hit, cfg_hit, exp_hit, exp_alias;
   logic              ht_hit, exp_ok;
   logic [GRAN_W-1:0] gran;

   assign win_hit   = addr[ADDR_W-1:ALIAS+1] == WIN_BASE[ADDR_W-1:ALIAS+1];
   assign cfg_hit   = (addr[ADDR_W-1:ALIAS+1] == CFG_BASE[ADDR_W-1:ALIAS+1]) &&
                      (addr[ALIAS-1:CFG_BITS] == CFG_BASE[ALIAS-1:CFG_BITS]);
   assign exp_hit   = (addr >= EXP_LO) && (addr <= EXP_HI);
   assign exp_alias = exp_en && addr[EXP_ALIAS_BIT] && (addr < EXP_ALIAS_END);
   assign gran      = addr[WIN_BITS-1:HT_GRAN_BITS];

   generate
      if (HAS_HT) begin : g_ht
         assign ht_hit = (gran >= ht_base) && (gran <= ht_limit);
         assign exp_ok = 1'b1;
      end else begin : g_no_ht
         assign ht_hit = 1'b0;
         assign exp_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      cls      = '{tgt: TGT_NONE, space: SP_MISS, pol: POL_BYTE, err: 1'b1};
      fwd_addr = addr;
      if (cfg_hit) begin
         cls             = '{tgt: TGT_PCI, space: SP_CFG, pol: br_pol_e'(addr[ALIAS]), err: 1'b0};
         fwd_addr[ALIAS] = 1'b0;
      end else if (win_hit) begin
         cls             = '{tgt: ht_hit ? TGT_HT : TGT_PCI, space: SP_WIN,
                             pol: br_pol_e'(addr[ALIAS]), err: 1'b0};
         fwd_addr[ALIAS] = 1'b0;
      end else if (exp_hit) begin
         if (exp_ok) begin
            cls = '{tgt: TGT_HT, space: SP_EXP, pol: exp_alias ? POL_BIT : POL_BYTE, err: 1'b0};
            if (exp_alias) fwd_addr[EXP_ALIAS_BIT] = 1'b0;
         end else begin
            cls = '{tgt: TGT_NONE, space: SP_EXP, pol: POL_BYTE, err: 1'b1};
         end
      end
   end
endmodule

// File: rtl/bridge_req_decode.sv
module bridge_req_decode #(
   parameter int                ADDR_W       = 40,
   parameter int                DATA_W       = 64,
   parameter logic [ADDR_W-1:0] WIN_BASE     = 40'h00_4000_0000,
   parameter logic [ADDR_W-1:0] CFG_BASE     = 40'h00_1E00_0000,
   parameter int                CFG_BITS     = 25,
   parameter int                HT_GRAN_BITS = 20,
   parameter bit                HAS_HT       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [8:0]        reg_wdata,
   input  logic              big_endian,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_target,
   output logic [1:0]        out_space,
   output logic              out_policy,
   output logic              out_err,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   import br_pkg::*;

   localparam int WIN_BITS = 29;
   localparam int GRAN_W   = WIN_BITS - HT_GRAN_BITS;

   generate
      if (DATA_W % 8 != 0)          begin : g_bad_data  $error("DATA_W must be whole bytes"); end
      if (ADDR_W != 40)             begin : g_bad_addr  $error("ADDR_W must be 40"); end
      if (GRAN_W != 9)              begin : g_bad_gran  $error("granule field must be 9 bits"); end
      if (CFG_BITS >= WIN_BITS)     begin : g_bad_cfg   $error("CFG_BITS too large"); end
      if (WIN_BASE[WIN_BITS:0] != '0) begin : g_bad_win $error("WIN_BASE misaligned"); end
   endgenerate

   logic [GRAN_W-1:0] ht_base, ht_limit;
   logic              exp_en;
   br_cls_t           cls;
   logic [ADDR_W-1:0] fwd_addr;
   logic [DATA_W-1:0] lane_data;
   logic              swap, accept;

   br_ht_regs #(.GRAN_W(GRAN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata[GRAN_W-1:0]),
      .ht_base(ht_base), .ht_limit(ht_limit), .exp_en(exp_en)
   );

   br_addr_class #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE),
      .CFG_BASE(CFG_BASE), .CFG_BITS(CFG_BITS), .HT_GRAN_BITS(HT_GRAN_BITS),
      .HAS_HT(HAS_HT)
   ) u_class (
      .addr(in_addr), .ht_base(ht_base), .ht_limit(ht_limit), .exp_en(exp_en),
      .cls(cls), .fwd_addr(fwd_addr)
   );

   assign swap = big_endian && (cls.pol == POL_BYTE) && !cls.err;

   br_lane_swap #(.DATA_W(DATA_W)) u_swap (
      .din(in_data), .swap(swap), .dout(lane_data)
   );

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_target <= '0;
         out_space  <= '0;
         out_policy <= 1'b0;
         out_err    <= 1'b0;
         out_addr   <= '0;
         out_data   <= '0;
      end else if (accept) begin
         out_valid  <= 1'b1;
         out_target <= cls.tgt;
         out_space  <= cls.space;
         out_policy <= cls.pol;
         out_err    <= cls.err;
         out_addr   <= fwd_addr;
         out_data   <= lane_data;
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/br_decode_chk.sv
module br_decode_chk #(
   parameter int ADDR_W = 40,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [1:0]        out_target,
   input logic [1:0]        out_space,
   input logic              out_policy,
   input logic              out_err,
   input logic [ADDR_W-1:0] out_addr,
   input logic [DATA_W-1:0] out_data
);
   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data) &&
      $stable(out_target) && $stable(out_space) && $stable(out_policy) && $stable(out_err));

   // window and configuration aliases both drop bit 29 (R7 as well)
   p_alias_gone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && out_space != 2'd1 |-> !out_addr[29]);

   p_exp_to_ht_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && out_space == 2'd1 |-> out_target == 2'd2);

   p_exp_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && out_space == 2'd1 && out_policy |-> !out_addr[38]);

   p_err_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err |-> out_target == 2'd0);
endmodule

bind bridge_req_decode br_decode_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_target(out_target),
   .out_space(out_space), .out_policy(out_policy), .out_err(out_err),
   .out_addr(out_addr), .out_data(out_data)
);

// File: tb/test_bridge_req_decode.sv
`timescale 1ns/1ps
module test_bridge_req_decode;
   typedef struct packed {
      logic        err;
      logic [1:0]  tgt;
      logic [1:0]  space;
      logic        pol;
      logic [39:0] addr;
      logic [63:0] data;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [8:0]  reg_wdata = '0;
   logic        big_endian = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [39:0] in_addr = '0;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [1:0]  out_target, out_space;
   logic        out_policy, out_err;
   logic [39:0] out_addr;
   logic [63:0] out_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int tb_base = 511, tb_limit = 0;
   bit tb_exp = 1'b0;
   item_t exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   bridge_req_decode i_bridge_req_decode (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .big_endian(big_endian), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_target(out_target), .out_space(out_space), .out_policy(out_policy),
      .out_err(out_err), .out_addr(out_addr), .out_data(out_data)
   );

   function automatic logic [63:0] byte_rev(logic [63:0] d);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
      return r;
   endfunction

   function automatic item_t model(logic [39:0] a, logic [63:0] d, bit be);
      item_t e;
      e = '{err: 1'b1, tgt: 2'd0, space: 2'd3, pol: 1'b0, addr: a, data: d};
      if ((a >= 40'h00_1E00_0000 && a <= 40'h00_1FFF_FFFF) ||
          (a >= 40'h00_3E00_0000 && a <= 40'h00_3FFF_FFFF)) begin
         e.err = 0; e.tgt = 1; e.space = 2; e.pol = (a >= 40'h00_3E00_0000);
         e.addr = e.pol ? a - 40'h00_2000_0000 : a;
      end else if (a >= 40'h00_4000_0000 && a <= 40'h00_7FFF_FFFF) begin
         int g;
         e.err = 0; e.space = 0; e.pol = (a >= 40'h00_6000_0000);
         e.addr = e.pol ? a - 40'h00_2000_0000 : a;
         g = int'((e.addr - 40'h00_4000_0000) >> 20);
         e.tgt = (g >= tb_base && g <= tb_limit) ? 2'd2 : 2'd1;
      end else if (a >= 40'h80_0000_0000 && a <= 40'hF7_FFFF_FFFF) begin
         e.err = 0; e.tgt = 2; e.space = 1;
         e.pol = tb_exp && a >= 40'hC0_0000_0000 && a < 40'hE0_0000_0000;
         e.addr = e.pol ? a - 40'h40_0000_0000 : a;
      end
      if (!e.err && be && !e.pol) e.data = byte_rev(d);
      return e;
   endfunction

   task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic wreg(logic [1:0] sel, logic [8:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
      case (sel)
         2'd0: tb_base = int'(val);
         2'd1: tb_limit = int'(val);
         default: tb_exp = val[0];
      endcase
   endtask

   task automatic send(logic [39:0] a, logic [63:0] d, bit be, string req);
      exp_q.push_back(model(a, d, be));
      tag_q.push_back(req);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a; in_data = d; big_endian = be;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1, "R10", "valid one edge after accept", 128'(out_valid), 128'(1));
   endtask

   // monitor: drives out_ready, pops expected items, checks holding
   logic [7:0] lfsr = 8'h5A;
   bit   held = 1'b0;
   item_t snap;
   always @(negedge clk) begin
      if (rst_n) begin
         item_t act;
         bit nr;
         act = '{err: out_err, tgt: out_target, space: out_space, pol: out_policy,
                 addr: out_addr, data: out_data};
         if (held)
            check(out_valid === 1'b1 && act === snap, "R10", "held output",
                  128'(act.addr), 128'(snap.addr));
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         nr = lfsr[0] | lfsr[1];
         out_ready = nr;
         held = out_valid && !nr;
         snap = act;
         if (out_valid && nr) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10", "unexpected output", 128'(act.addr), 128'(0));
            end else begin
               item_t e;
               string r;
               e = exp_q.pop_front();
               r = tag_q.pop_front();
               if (e.err)
                  check(act.err && act.tgt == e.tgt && act.space == e.space, r, "error item",
                        128'({act.err, act.tgt, act.space}), 128'({e.err, e.tgt, e.space}));
               else
                  check(act === e, r, "decoded item", 128'({act.tgt, act.space, act.pol, act.addr}),
                        128'({e.tgt, e.space, e.pol, e.addr}));
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(out_valid === 1'b0, "R1", "valid after reset", 128'(out_valid), 128'(0));
      check(in_ready === 1'b1, "R1", "ready after reset", 128'(in_ready), 128'(1));
      // R1: sub-range empty after reset
      send(40'h00_4000_0008, 64'h0102_0304_0506_0708, 1'b0, "R1");
      send(40'h00_4012_3450, 64'h0102_0304_0506_0708, 1'b1, "R2");
      send(40'h00_5FFF_FFF8, 64'h1111_2222_3333_4444, 1'b0, "R2");
      send(40'h00_6012_3450, 64'h0102_0304_0506_0708, 1'b1, "R3");
      send(40'h00_7FFF_FFF0, 64'hDEAD_BEEF_0000_0001, 1'b1, "R9");
      send(40'h00_4000_1000, 64'hA1B2_C3D4_E5F6_0718, 1'b1, "R9");
      wreg(2'd0, 9'd3);
      wreg(2'd1, 9'd5);
      send(40'h00_4030_0000, 64'h1, 1'b0, "R4");
      send(40'h00_402F_FFF8, 64'h2, 1'b0, "R4");
      send(40'h00_405F_FFF8, 64'h3, 1'b0, "R4");
      send(40'h00_4060_0000, 64'h4, 1'b0, "R4");
      send(40'h00_6040_0000, 64'h5, 1'b1, "R11");
      send(40'h80_0000_0000, 64'h0123_4567_89AB_CDEF, 1'b1, "R5");
      send(40'hC0_1234_5678, 64'h0123_4567_89AB_CDEF, 1'b1, "R5");
      send(40'hF7_FFFF_FFF8, 64'h6, 1'b0, "R5");
      wreg(2'd2, 9'd1);
      send(40'hC0_0000_0000, 64'h0123_4567_89AB_CDEF, 1'b1, "R6");
      send(40'hDF_FFFF_FFF8, 64'h7, 1'b0, "R6");
      send(40'hBF_FFFF_FFF8, 64'h0123_4567_89AB_CDEF, 1'b1, "R6");
      send(40'hE0_0000_0000, 64'h8, 1'b0, "R6");
      send(40'h00_1E00_0100, 64'h0102_0304_0506_0708, 1'b1, "R7");
      send(40'h00_3E00_0100, 64'h0102_0304_0506_0708, 1'b1, "R7");
      send(40'hF8_0000_0000, 64'h9, 1'b0, "R8");
      send(40'h00_0000_1000, 64'hA, 1'b0, "R8");
      send(40'h00_8000_0000, 64'hB, 1'b1, "R8");
      wreg(2'd0, 9'd0);
      wreg(2'd1, 9'd0);
      send(40'h00_400F_FFF8, 64'hC, 1'b0, "R11");
      send(40'h00_4010_0000, 64'hD, 1'b0, "R11");
      for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
      check(exp_q.size() == 0, "R10", "all results drained", 128'(exp_q.size()), 128'(0));
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule